// File: doc/BRIEF.md
# Blocked Access Capture and Interrupt

This block sits next to a memory security gate. Whenever the gate rejects a transaction it raises a one-cycle strobe together with the faulting address, the requester ID, the requester's secure flag and the per-block table bit that governed the decision. The first such event is recorded into two capture registers and sets a sticky status flag. Events that arrive later are still flagged but do not disturb the record, so software always sees the first violation since it last cleared the flag.

Software controls the flag through three write strobes that share one data word: a clear strobe, a set strobe that forces the flag for testing, and an enable strobe. The interrupt line is high while the flag and the enable bit are both set. Register decode and the blocking decision itself sit outside this block.

Top module: `viol_capture`

## Requirements
- R1: A blocked event while the status flag is clear loads the full event address into the first capture register and sets the flag; both are visible on the cycle after the event.
- R2: In that same event the second capture register takes requester ID bits [15:0] in bits 15:0, the inverse of the secure flag in bit 16, the table bit in bit 17, and zero in bits 31:18.
- R3: A blocked event while the flag is already set leaves both capture registers unchanged.
- R4: The interrupt output is high exactly when the flag and the enable bit are both set, in the same cycle as those registers.
- R5: A clear strobe with data bit 0 set clears the flag on the next cycle; a set strobe with data bit 0 set sets it; either strobe with data bit 0 at zero has no effect.
- R6: An enable strobe stores data bit 0 as the enable bit and ignores all other data bits.
- R7: After reset the flag is 0, both capture registers are 0 and the enable bit is 1.
- R8: A blocked event and a clear strobe in the same cycle leave the flag set, and the event is captured if the flag was clear before.
- R9: A set strobe and a clear strobe in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | One-cycle strobe: a transaction was rejected |
| blk_addr | input | ADDR_W | Address of the rejected transaction |
| blk_rid | input | RID_W | Requester ID of the rejected transaction |
| blk_secure | input | 1 | Secure flag of the rejected transaction |
| blk_tbl | input | 1 | Table bit of the block holding the address |
| set_wr | input | 1 | Write strobe of the set register |
| clr_wr | input | 1 | Write strobe of the clear register |
| en_wr | input | 1 | Write strobe of the enable register |
| wdata | input | 32 | Write data shared by the three strobes |
| status | output | 1 | Sticky violation flag |
| enable | output | 1 | Interrupt enable bit |
| info_addr | output | ADDR_W | First capture register: faulting address |
| info_attr | output | 32 | Second capture register: ID, inverted secure flag, table bit |
| irq | output | 1 | Level interrupt |

## Verification
A flag stuck or wrongly cleared shows on status and irq one cycle after the offending strobe, and a lost arming condition shows as capture registers that change while the flag is set, visible on the very next cycle. The bench keeps its own model of the flag, enable bit and both records and compares every output at each clock, so a divergence is reported in the cycle it first reaches the ports. Directed sequences cover the same-cycle collisions of event, set and clear, and a long random phase mixes all strobes.

// File: rtl/viol_pkg.sv
// Package: shared layout of the attribute capture word.
// Assumes a 32-bit register width for the attribute word.
package viol_pkg;
    localparam int WORD_W = 32;
    localparam int ID_KEEP = 16;

    typedef struct packed {
        logic [WORD_W-ID_KEEP-3:0] pad;     // always zero
        logic                      tbl_bit; // bit 17
        logic                      nonsec;  // bit 16
        logic [ID_KEEP-1:0]        rid;     // bits 15:0
    } attr_word_t;
endpackage

// File: rtl/viol_flag.sv
// Module: sticky violation flag, enable bit and interrupt level.
// Assumes set/clear requests are already qualified by data bit 0.
module viol_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_hit,
    input  logic set_req,
    input  logic clr_req,
    input  logic en_wr,
    input  logic en_bit,
    output logic status,
    output logic enable,
    output logic irq
);
    // Flag update: events and set requests dominate clear requests.
    always_ff @(posedge clk) begin
        if (!rst_n)                  status <= 1'b0;
        else if (blk_hit || set_req) status <= 1'b1;
        else if (clr_req)            status <= 1'b0;
    end

    // Enable bit: single stored bit, resets to enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= 1'b1;
        else if (en_wr) enable <= en_bit;
    end

    assign irq = status & enable;

    a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_hit && clr_req) |=> status);
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && clr_req) |=> status);
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !blk_hit && !set_req) |=> !status);
    a_r6_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (enable == $past(en_bit)));
endmodule

// File: rtl/viol_latch.sv
// Module: capture registers for the first rejected transaction.
// Assumes 'armed' is high only while the violation flag is clear.
module viol_latch
    import viol_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RID_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              blk_valid,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic [RID_W-1:0]  blk_rid,
    input  logic              blk_secure,
    input  logic              blk_tbl,
    output logic [ADDR_W-1:0] info_addr,
    output attr_word_t        info_attr
);
    logic take;
    attr_word_t attr_next;

    assign take = blk_valid && armed;

    // Assemble the attribute word from the event fields.
    always_comb begin
        attr_next         = '0;
        attr_next.rid     = blk_rid[ID_KEEP-1:0];
        attr_next.nonsec  = ~blk_secure;
        attr_next.tbl_bit = blk_tbl;
    end

    // Load both records only on the first event after arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_addr <= '0;
            info_attr <= '0;
        end else if (take) begin
            info_addr <= blk_addr;
            info_attr <= attr_next;
        end
    end

    a_r1_addr_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && armed) |=> (info_addr == $past(blk_addr)));
    a_r2_nonsec_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && armed) |=> (info_attr.nonsec == !$past(blk_secure)));
    a_r3_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> ($stable(info_addr) && $stable(info_attr)));
endmodule

// File: rtl/viol_capture.sv
// Module: top of the blocked-access capture and interrupt block.
// Assumes strobes are single-cycle and wdata is valid with any strobe.
module viol_capture
    import viol_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RID_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic [RID_W-1:0]  blk_rid,
    input  logic              blk_secure,
    input  logic              blk_tbl,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic              en_wr,
    input  logic [31:0]       wdata,
    output logic              status,
    output logic              enable,
    output logic [ADDR_W-1:0] info_addr,
    output logic [31:0]       info_attr,
    output logic              irq
);
    logic       set_req, clr_req;
    attr_word_t attr_q;

    // Only bit 0 of the write data acts on set and clear.
    assign set_req = set_wr && wdata[0];
    assign clr_req = clr_wr && wdata[0];

    viol_flag i_flag (
        .clk(clk), .rst_n(rst_n), .blk_hit(blk_valid),
        .set_req(set_req), .clr_req(clr_req),
        .en_wr(en_wr), .en_bit(wdata[0]),
        .status(status), .enable(enable), .irq(irq)
    );

    viol_latch #(.ADDR_W(ADDR_W), .RID_W(RID_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .armed(!status),
        .blk_valid(blk_valid), .blk_addr(blk_addr), .blk_rid(blk_rid),
        .blk_secure(blk_secure), .blk_tbl(blk_tbl),
        .info_addr(info_addr), .info_attr(attr_q)
    );

    assign info_attr = attr_q;

    a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status && enable));
    a_r1_flag_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |=> status);
endmodule

// File: tb/test_viol_capture.sv
`timescale 1ns/1ps
module test_viol_capture;
    localparam int AW = 32;
    localparam int RW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_valid = 0, blk_secure = 0, blk_tbl = 0;
    logic [AW-1:0] blk_addr = '0;
    logic [RW-1:0] blk_rid = '0;
    logic set_wr = 0, clr_wr = 0, en_wr = 0;
    logic [31:0] wdata = '0;
    logic status, enable, irq;
    logic [AW-1:0] info_addr;
    logic [31:0] info_attr;

    int checks = 0, fails = 0;

    // reference model state
    bit m_st, m_en;
    logic [31:0] m_i1, m_i2;

    always #2.5 clk = ~clk;

    viol_capture #(.ADDR_W(AW), .RID_W(RW)) i_viol_capture (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_addr(blk_addr),
        .blk_rid(blk_rid), .blk_secure(blk_secure), .blk_tbl(blk_tbl),
        .set_wr(set_wr), .clr_wr(clr_wr), .en_wr(en_wr), .wdata(wdata),
        .status(status), .enable(enable), .info_addr(info_addr),
        .info_attr(info_attr), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model of the requirements, stepped on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_en = 1; m_i1 = 0; m_i2 = 0;               // R7
        end else begin
            bit first;
            first = blk_valid && !m_st;
            if (first) begin                                        // R1, R2
                m_i1 = blk_addr;
                m_i2 = {14'd0, blk_tbl, ~blk_secure, blk_rid[15:0]};
            end
            if (blk_valid || (set_wr && wdata[0])) m_st = 1;       // R8, R9
            else if (clr_wr && wdata[0]) m_st = 0;                 // R5
            if (en_wr) m_en = wdata[0];                             // R6
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1/R3 info_addr", info_addr, m_i1);
            chk("R2/R3 info_attr", info_attr, m_i2);
            chk("R5 status", {31'd0, status}, {31'd0, m_st});
            chk("R6 enable", {31'd0, enable}, {31'd0, m_en});
            chk("R4 irq", {31'd0, irq}, {31'd0, m_st & m_en});
        end
    end

    task automatic idle();
        blk_valid = 0; set_wr = 0; clr_wr = 0; en_wr = 0; wdata = 0;
    endtask

    task automatic step();
        @(negedge clk);
        #0.1;
    endtask

    task automatic ev(logic [31:0] a, logic [15:0] r, logic s, logic t);
        blk_valid = 1; blk_addr = a; blk_rid = r; blk_secure = s; blk_tbl = t;
    endtask

    task automatic run_main();
        rst_n = 0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        chk("R7 reset status", {31'd0, status}, 32'd0);
        chk("R7 reset enable", {31'd0, enable}, 32'd1);
        chk("R7 reset info", info_addr | info_attr, 32'd0);
        // first capture
        ev(32'hDEAD_BEE0, 16'h1234, 1'b0, 1'b1); step(); idle();
        chk("R1 addr", info_addr, 32'hDEAD_BEE0);
        chk("R2 attr", info_attr, 32'h0003_1234);
        chk("R4 irq on", {31'd0, irq}, 32'd1);
        // second event does not overwrite
        ev(32'h0000_1000, 16'hFFFF, 1'b1, 1'b0); step(); idle();
        chk("R3 hold addr", info_addr, 32'hDEAD_BEE0);
        chk("R3 hold attr", info_attr, 32'h0003_1234);
        // clear with bit0 = 0 does nothing
        clr_wr = 1; wdata = 32'hFFFF_FFFE; step(); idle();
        chk("R5 zero clear ignored", {31'd0, status}, 32'd1);
        // disable: irq drops, status stays
        en_wr = 1; wdata = 32'hFFFF_FFFE; step(); idle();
        chk("R6 enable off", {31'd0, enable}, 32'd0);
        chk("R4 irq masked", {31'd0, irq}, 32'd0);
        en_wr = 1; wdata = 32'h0000_0001; step(); idle();
        chk("R6 enable on", {31'd0, enable}, 32'd1);
        // real clear
        clr_wr = 1; wdata = 1; step(); idle();
        chk("R5 cleared", {31'd0, status}, 32'd0);
        chk("R4 irq off", {31'd0, irq}, 32'd0);
        // set with bit0 = 0 ignored, then set
        set_wr = 1; wdata = 32'h2; step(); idle();
        chk("R5 zero set ignored", {31'd0, status}, 32'd0);
        set_wr = 1; wdata = 1; step(); idle();
        chk("R5 set", {31'd0, status}, 32'd1);
        // set + clear same cycle
        set_wr = 1; clr_wr = 1; wdata = 1; step(); idle();
        chk("R9 set wins", {31'd0, status}, 32'd1);
        clr_wr = 1; wdata = 1; step(); idle();
        // event + clear same cycle while clear: captured and flagged
        ev(32'h0BAD_F00D, 16'h00A5, 1'b1, 1'b0); clr_wr = 1; wdata = 1; step(); idle();
        chk("R8 flagged", {31'd0, status}, 32'd1);
        chk("R8 captured", info_addr, 32'h0BAD_F00D);
        chk("R8 attr", info_attr, 32'h0000_00A5);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            idle();
            blk_valid = ($urandom_range(0, 3) == 0);
            blk_addr = $urandom; blk_rid = 16'($urandom);
            blk_secure = 1'($urandom); blk_tbl = 1'($urandom);
            set_wr = ($urandom_range(0, 9) == 0);
            clr_wr = ($urandom_range(0, 3) == 0);
            en_wr = ($urandom_range(0, 7) == 0);
            wdata = $urandom;
            step();
        end
        idle();
        step();
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule